// File: doc/BRIEF.md
# E3 Transmit Payload Input Interface

This block takes outbound E3 payload from terminal equipment and delivers it, one bit at a time, to a downstream transmit framer. Terminal data arrives either bit-serially on a single pin or as four-bit nibbles. The whole block runs on one fast system clock. The two candidate bit clocks reach it as single-cycle enable strobes. One strobe comes from the recovered receive line clock and is used for loop timing. The other comes from a local transmit input clock and is used for local timing.

Under local timing the block is either frame master or frame slave. As master, its own 1536-bit frame counter decides where frames begin. As slave, the terminal marks a new frame with a frame-start input.

The block returns a payload clock strobe to the terminal, which marks each word boundary. It also returns a frame indication that is high for the period of the last bit of each frame, or for the last nibble in nibble mode. The framer side is a stream with no ready signal. The E3 line rate cannot be stalled, so the framer must accept every beat on the cycle that `out_valid` is high. Configuration pins are static between resets.

Top module: `e3_tx_payload_in`

## Requirements
- R1: Synchronous active-high reset clears the frame counter, `out_valid`, `out_sof` and `misalign`. The first bit taken after reset is bit 0 of a frame.
- R2: With `cfg_loop`=1, bit periods are the cycles where `rx_line_tick` is high. `tx_local_tick` has no effect.
- R3: With `cfg_loop`=0, bit periods are the cycles where `tx_local_tick` is high. `rx_line_tick` has no effect.
- R4: With `cfg_nibble`=0, `term_tick` is high in every bit period. `term_ser` is sampled in that cycle, and on the next cycle it appears on `out_bit` with `out_valid` high.
- R5: With `cfg_nibble`=1, `term_tick` is high only in the bit period that begins a nibble, which is a frame index that is a multiple of 4. `term_nib` is captured then, and its bits are sent out MSB first (bit 3, 2, 1, 0) over four consecutive bit periods.
- R6: Frames are 1536 bits long, indexed 0 to 1535. `out_sof` is high together with `out_valid` exactly for the beat that carries index 0.
- R7: In serial mode, `term_frame` is high exactly while the next bit to be taken has index 1535. In nibble mode it is high while that index is between 1532 and 1535.
- R8: Slave mode is `cfg_loop`=0 with `cfg_master`=0. In slave mode, `term_fstart` high in a bit period makes that bit index 0, and counting continues from there.
- R9: A slave frame-start that arrives when the expected index is not 0 sets `misalign`. `misalign` then stays set until reset.
- R10: In loop mode and in master mode, `term_fstart` has no effect on indexing or on `misalign`.
- R11: `out_valid` is high only on the cycle after a bit period, and exactly one beat is produced per bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nibble | input | 1 | 1 = nibble-parallel, 0 = serial |
| cfg_loop | input | 1 | 1 = loop timing, 0 = local timing |
| cfg_master | input | 1 | Local timing: 1 = frame master, 0 = frame slave |
| rx_line_tick | input | 1 | Recovered receive clock bit strobe |
| tx_local_tick | input | 1 | Local transmit clock bit strobe |
| term_ser | input | 1 | Serial payload from terminal |
| term_nib | input | NIB_W | Nibble payload from terminal, MSB sent first |
| term_fstart | input | 1 | Terminal frame-start mark (slave mode) |
| term_tick | output | 1 | Payload clock strobe to terminal |
| term_frame | output | 1 | Last-bit / last-nibble frame indication |
| out_valid | output | 1 | Beat valid toward framer (no back-pressure) |
| out_bit | output | 1 | Payload bit toward framer |
| out_sof | output | 1 | Beat is frame index 0 |
| misalign | output | 1 | Sticky slave frame-start misalignment |

## Verification
The assertions check several rules on every clock. They confirm that the unused clock strobe never produces a beat, that every beat follows a bit period, and that serial and nibble-MSB data land on `out_bit` one cycle later. They also check that a slave frame-start yields `out_sof`, that `misalign` is sticky, and that `misalign` is never set outside slave mode. Other properties depend on counting, and only the bench's reference model can show them: `term_frame` falling exactly on index 1535 or 1532, the later nibble bits arriving in MSB-first order, and wrap-around at 1536 across several frames. Each scenario uses one of the six mode combinations with random strobes, random data and both aligned and misaligned frame-starts.

// File: rtl/e3tp_pkg.sv
package e3tp_pkg;
  typedef enum logic [1:0] {
    TM_LOOP         = 2'd0,
    TM_LOCAL_MASTER = 2'd1,
    TM_LOCAL_SLAVE  = 2'd2
  } tmode_e;

  function automatic tmode_e decode_tmode(input logic loop_sel, input logic master_sel);
    if (loop_sel)   return TM_LOOP;
    if (master_sel) return TM_LOCAL_MASTER;
    return TM_LOCAL_SLAVE;
  endfunction
endpackage

// File: rtl/e3tp_tick_sel.sv
module e3tp_tick_sel
  import e3tp_pkg::*;
(
  input  logic cfg_loop,
  input  logic cfg_master,
  input  logic rx_line_tick,
  input  logic tx_local_tick,
  input  logic term_fstart,
  output logic bit_tick,
  output logic fs_hit
);
  tmode_e mode;

  always_comb begin
    mode = decode_tmode(cfg_loop, cfg_master);
    unique case (mode)
      TM_LOOP:  bit_tick = rx_line_tick;
      default:  bit_tick = tx_local_tick;
    endcase
    fs_hit = (mode == TM_LOCAL_SLAVE) && bit_tick && term_fstart;
  end
endmodule

// File: rtl/e3tp_bit_cnt.sv
module e3tp_bit_cnt #(
  parameter int FRAME_BITS = 1536,
  parameter int NIB_W      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_nibble,
  input  logic bit_tick,
  input  logic fs_hit,
  output logic nib_start,
  output logic first_bit,
  output logic term_frame,
  output logic misalign
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int NB_W  = $clog2(NIB_W);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] NIB_FIRST = CNT_W'(FRAME_BITS - NIB_W);
  localparam logic [CNT_W-1:0] ZERO_IDX  = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             mis_q;

  always_comb begin
    idx        = fs_hit ? ZERO_IDX : cnt_q;
    nib_start  = (idx[NB_W-1:0] == '0);
    first_bit  = (idx == ZERO_IDX);
    term_frame = cfg_nibble ? (cnt_q >= NIB_FIRST) : (cnt_q == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mis_q <= 1'b0;
    end else begin
      if (bit_tick)
        cnt_q <= (idx == LAST_IDX) ? ZERO_IDX : idx + CNT_W'(1);
      if (fs_hit && (cnt_q != ZERO_IDX))
        mis_q <= 1'b1;
    end
  end

  assign misalign = mis_q;
endmodule

// File: rtl/e3tp_capture.sv
module e3tp_capture #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_nibble,
  input  logic             bit_tick,
  input  logic             nib_start,
  input  logic             first_bit,
  input  logic             term_ser,
  input  logic [NIB_W-1:0] term_nib,
  output logic             term_tick,
  output logic             out_valid,
  output logic             out_bit,
  output logic             out_sof
);
  logic [NIB_W-1:0] sh_q;
  logic             load;
  logic             nxt_bit;

  always_comb begin
    load      = cfg_nibble && bit_tick && nib_start;
    term_tick = cfg_nibble ? load : bit_tick;
    if (!cfg_nibble)
      nxt_bit = term_ser;
    else if (load)
      nxt_bit = term_nib[NIB_W-1];
    else
      nxt_bit = sh_q[NIB_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      if (load)
        sh_q <= {term_nib[NIB_W-2:0], 1'b0};
      else if (bit_tick)
        sh_q <= {sh_q[NIB_W-2:0], 1'b0};
      out_valid <= bit_tick;
      out_sof   <= bit_tick && first_bit;
      if (bit_tick)
        out_bit <= nxt_bit;
    end
  end
endmodule

// File: rtl/e3_tx_payload_in.sv
module e3_tx_payload_in #(
  parameter int FRAME_BITS = 1536,
  parameter int NIB_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_nibble,
  input  logic             cfg_loop,
  input  logic             cfg_master,
  input  logic             rx_line_tick,
  input  logic             tx_local_tick,
  input  logic             term_ser,
  input  logic [NIB_W-1:0] term_nib,
  input  logic             term_fstart,
  output logic             term_tick,
  output logic             term_frame,
  output logic             out_valid,
  output logic             out_bit,
  output logic             out_sof,
  output logic             misalign
);
  logic bit_tick;
  logic fs_hit;
  logic nib_start;
  logic first_bit;

  e3tp_tick_sel u_tick (
    .cfg_loop      (cfg_loop),
    .cfg_master    (cfg_master),
    .rx_line_tick  (rx_line_tick),
    .tx_local_tick (tx_local_tick),
    .term_fstart   (term_fstart),
    .bit_tick      (bit_tick),
    .fs_hit        (fs_hit)
  );

  e3tp_bit_cnt #(.FRAME_BITS(FRAME_BITS), .NIB_W(NIB_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cfg_nibble (cfg_nibble),
    .bit_tick   (bit_tick),
    .fs_hit     (fs_hit),
    .nib_start  (nib_start),
    .first_bit  (first_bit),
    .term_frame (term_frame),
    .misalign   (misalign)
  );

  e3tp_capture #(.NIB_W(NIB_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .cfg_nibble (cfg_nibble),
    .bit_tick   (bit_tick),
    .nib_start  (nib_start),
    .first_bit  (first_bit),
    .term_ser   (term_ser),
    .term_nib   (term_nib),
    .term_tick  (term_tick),
    .out_valid  (out_valid),
    .out_bit    (out_bit),
    .out_sof    (out_sof)
  );
endmodule

// File: rtl/e3_tx_payload_in_chk.sv
module e3_tx_payload_in_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_nibble,
  input logic             cfg_loop,
  input logic             cfg_master,
  input logic             rx_line_tick,
  input logic             tx_local_tick,
  input logic             term_ser,
  input logic [NIB_W-1:0] term_nib,
  input logic             term_fstart,
  input logic             term_tick,
  input logic             term_frame,
  input logic             out_valid,
  input logic             out_bit,
  input logic             out_sof,
  input logic             misalign
);
  logic tk;
  logic slv;
  assign tk  = cfg_loop ? rx_line_tick : tx_local_tick;
  assign slv = !cfg_loop && !cfg_master;

  p_reset_r1: assert property (@(posedge clk) $past(rst) |-> (!out_valid && !misalign && !out_sof));
  p_loop_ignores_local_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_loop && !rx_line_tick) |=> !out_valid);
  p_local_ignores_line_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_loop && !tx_local_tick) |=> !out_valid);
  p_serial_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_nibble && tk) |=> (out_valid && out_bit == $past(term_ser)));
  p_nibble_msb_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_nibble && term_tick) |=> (out_valid && out_bit == $past(term_nib[NIB_W-1])));
  p_tick_in_period_r5: assert property (@(posedge clk) disable iff (rst)
    term_tick |-> tk);
  p_sof_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  p_frame_wraps_r7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_nibble && term_frame && tk && !(slv && term_fstart)) |=> !term_frame);
  p_slave_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (slv && tk && term_fstart) |=> out_sof);
  p_mis_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    misalign |=> misalign);
  p_mis_slave_only_r10: assert property (@(posedge clk) disable iff (rst)
    (!slv && !misalign) |=> !misalign);
  p_valid_after_tick_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tk));
endmodule

bind e3_tx_payload_in e3_tx_payload_in_chk #(.NIB_W(NIB_W)) u_chk (.*);

// File: tb/sim_e3_tx_payload_in.sv
`timescale 1ns/100ps
module sim_e3_tx_payload_in;
  localparam int FB = 1536;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_nibble = 1'b0, cfg_loop = 1'b1, cfg_master = 1'b0;
  logic rx_line_tick = 1'b0, tx_local_tick = 1'b0;
  logic term_ser = 1'b0;
  logic [3:0] term_nib = 4'h0;
  logic term_fstart = 1'b0;
  logic term_tick, term_frame, out_valid, out_bit, out_sof, misalign;

  e3_tx_payload_in u0 (.*);

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // reference model state
  int m_cnt;
  bit m_valid, m_bit, m_sof, m_mis;
  bit m_q[$];

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit is_slave();
    return !cfg_loop && !cfg_master;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rx_line_tick = 0; tx_local_tick = 0; term_fstart = 0; term_ser = 0; term_nib = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", out_valid, 1'b0);
    chk("R1", "misalign in reset", misalign, 1'b0);
    chk("R1", "out_sof in reset", out_sof, 1'b0);
    rst = 1'b0;
    m_cnt = 0; m_valid = 0; m_bit = 0; m_sof = 0; m_mis = 0;
    m_q.delete();
  endtask

  task automatic run(input bit nib, input bit lp, input bit ms, input int ncyc, input int mis_at);
    bit mis_done;
    mis_done = 1'b0;
    cfg_nibble = nib; cfg_loop = lp; cfg_master = ms;
    do_reset();
    for (int c = 0; c < ncyc; c++) begin
      bit tk, hit, b;
      int idx;
      @(negedge clk);
      chk(lp ? "R2" : "R3", "out_valid", out_valid, m_valid);
      chk(is_slave() ? "R8" : "R6", "out_sof", out_sof, m_sof);
      chk(is_slave() ? "R9" : "R10", "misalign", misalign, m_mis);
      if (m_valid) chk(nib ? "R5" : "R4", "out_bit", out_bit, m_bit);
      rx_line_tick  = ($urandom % 3) != 0;
      tx_local_tick = ($urandom % 3) != 0;
      term_ser = 1'($urandom);
      term_nib = 4'($urandom);
      tk = lp ? rx_line_tick : tx_local_tick;
      if (is_slave()) begin
        term_fstart = 1'b0;
        if (tk && m_cnt == 0) term_fstart = 1'b1;
        if (tk && m_cnt != 0 && !mis_done && mis_at >= 0 && c >= mis_at) begin
          term_fstart = 1'b1;
          mis_done = 1'b1;
        end
      end else begin
        term_fstart = ($urandom % 5) == 0;
      end
      #0.5;
      hit = is_slave() && tk && term_fstart;
      idx = hit ? 0 : m_cnt;
      chk(nib ? "R5" : "R4", "term_tick", term_tick, nib ? (tk && (idx % 4) == 0) : tk);
      chk("R7", "term_frame", term_frame, nib ? (m_cnt >= FB - 4) : (m_cnt == FB - 1));
      // advance model over the coming edge
      if (tk) begin
        if (nib) begin
          if ((idx % 4) == 0) begin
            b = term_nib[3];
            m_q.delete();
            m_q.push_back(term_nib[2]); m_q.push_back(term_nib[1]); m_q.push_back(term_nib[0]);
          end else begin
            b = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
          end
        end else begin
          b = term_ser;
        end
        if (hit && m_cnt != 0) m_mis = 1'b1;
        m_valid = 1'b1; m_bit = b; m_sof = (idx == 0);
        m_cnt = (idx + 1) % FB;
      end else begin
        m_valid = 1'b0; m_sof = 1'b0;
      end
    end
  endtask

  initial begin
    run(1'b0, 1'b1, 1'b0, 5000, -1);  // serial loop
    run(1'b0, 1'b0, 1'b1, 5000, -1);  // serial local master
    run(1'b0, 1'b0, 1'b0, 5000, 3000); // serial local slave, one misaligned start
    run(1'b1, 1'b1, 1'b1, 5000, -1);  // nibble loop
    run(1'b1, 1'b0, 1'b1, 5000, -1);  // nibble local master
    run(1'b1, 1'b0, 1'b0, 5000, 2500); // nibble local slave, one misaligned start
    do_reset();                        // R1: sticky flag cleared by reset
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule